// File: doc/BRIEF.md
# Prescaled High/Low-Time PWM Channel

This block drives one pulse-width-modulated output. The length of the high phase and the length of the low phase each come from a 16-bit register of their own, so the output does not use a period value paired with a compare value. One shared counter times whichever phase is active and restarts from zero at every phase change. A set/reset output latch holds the level. A base tick enable is shared by every channel of a chip. Each channel divides that tick by a power of two that it selects itself. This keeps all channels on one timebase while each one picks its own resolution and range.

A simple write port loads the configuration. High time, low time and divider exponent go into shadow registers and are copied into the working set only when a new period begins, so a period in progress always finishes with the values it started with. A control word sets the enable bit and selects whether the channel starts at once or waits for a rising edge on an external event pin. The event pin is synchronized first. Several channels that wait on the same pin therefore start together.

Top module: `pwm_hilo_channel`

## Requirements
- R1: After reset the output is low and the channel is idle until its enable bit is written to 1.
- R2: While running, every high phase lasts exactly HIGH × 2^n base ticks. HIGH is written at address 0 and n is the divider exponent.
- R3: While running, every low phase lasts exactly LOW × 2^n base ticks. LOW is written at address 1.
- R4: The divider exponent n is taken from bits [2:0] of the control word at address 2, and every value from 0 to 7 is honoured.
- R5: Writes to HIGH, LOW and n during a period do not change that period. They take effect from the high phase that follows the end of the current low phase.
- R6: When HIGH is 0 the running output stays constantly low.
- R7: When LOW is 0 and HIGH is non-zero the running output stays constantly high.
- R8: When the control word is written with enable (bit 3) set and event mode (bit 4) clear, the output goes high on the second rising clock edge after the write is sampled.
- R9: When the control word is written with enable clear, the output is low from the second rising clock edge after the write is sampled and stays low.
- R10: With enable and event mode both set, the channel waits with its output low. It starts (output high) on the third rising clock edge after the event input rises, because the event passes through a two-flop synchronizer and an edge detector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Shared timebase enable, one clock wide per tick |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 high time, 1 low time, 2 control |
| cfg_wdata | input | 16 | Write data |
| evt_in | input | 1 | Asynchronous start event |
| pwm_out | output | 1 | PWM output |

## Verification
Control writes take effect on the first clock edge that samples them. The output follows one edge later (R8, R9). An event rise reaches the output on the third edge (R10). The bench samples on falling edges and checks at exactly those counts. Phase lengths (R2 to R5) are checked by a monitor that measures each completed run of the output in clock cycles and compares it with the value the driver queued, which is HIGH or LOW × 2^n × the tick spacing of two cycles. The first two runs after an enable are skipped, because the idle stretch and the first high phase depend on where the tick falls relative to the start. The shadow test arms the monitor only after a rising edge of the output, so the high phase in progress is compared against the old settings.

// File: rtl/pwm_hilo_pkg.sv
package pwm_hilo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        ADR_HIGH = 2'd0,
        ADR_LOW  = 2'd1,
        ADR_CTRL = 2'd2
    } cfg_addr_e;

endpackage

// File: rtl/pwm_evt_sync.sv
module pwm_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    output logic rise_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[DEPTH-2:0], evt_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];

    // a detected rise lasts exactly one cycle
    assert_single_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o)
        else $error("event rise held longer than one cycle");

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             step_o
);
    localparam int PC_W = (1 << DIV_W) - 1;
    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    logic [PC_W-1:0] pc_d, pc_q;
    logic [PC_W-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < PC_W; i++) begin
            if (i < int'(div_i)) mask[i] = 1'b1;
        end
    end

    assign step_o = run_i && tick_i && (pc_q == mask);

    always_comb begin
        pc_d = pc_q;
        if (!run_i)      pc_d = '0;
        else if (step_o) pc_d = '0;
        else if (tick_i) pc_d = pc_q + PC_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // the tick count never passes the limit chosen by the exponent
    assert_pc_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q <= mask)
        else $error("prescaler count above divider limit");

endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer
    import pwm_hilo_pkg::*;
#(
    parameter int TIME_W = 16,
    parameter int DIV_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              evm_i,
    input  logic              evt_rise_i,
    input  logic              step_i,
    input  logic [TIME_W-1:0] sh_hi_i,
    input  logic [TIME_W-1:0] sh_lo_i,
    input  logic [DIV_W-1:0]  sh_div_i,
    output logic              running_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              pwm_o
);
    localparam logic [TIME_W-1:0] CNT_ONE = TIME_W'(1);

    typedef struct packed {
        run_state_e        state;
        logic              ph;
        logic [TIME_W-1:0] cnt;
        logic [TIME_W-1:0] act_hi;
        logic [TIME_W-1:0] act_lo;
        logic [DIV_W-1:0]  act_div;
        logic              lat;
    } tmr_t;

    tmr_t t_d, t_q;
    logic load;
    logic [TIME_W-1:0] cnt_inc;

    assign cnt_inc = t_q.cnt + CNT_ONE;

    always_comb begin
        t_d  = t_q;
        load = 1'b0;
        case (t_q.state)
            ST_IDLE: begin
                if (en_i) begin
                    if (evm_i) t_d.state = ST_WAIT;
                    else begin
                        t_d.state = ST_RUN;
                        load      = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (!en_i) t_d.state = ST_IDLE;
                else if (evt_rise_i) begin
                    t_d.state = ST_RUN;
                    load      = 1'b1;
                end
            end
            ST_RUN: begin
                if (!en_i) t_d.state = ST_IDLE;
                else if (step_i) begin
                    if (t_q.act_hi == '0 || t_q.act_lo == '0) begin
                        load = 1'b1;
                    end else if (t_q.ph) begin
                        if (cnt_inc == t_q.act_hi) begin
                            t_d.ph  = 1'b0;
                            t_d.cnt = '0;
                        end else begin
                            t_d.cnt = cnt_inc;
                        end
                    end else begin
                        if (cnt_inc == t_q.act_lo) load = 1'b1;
                        else                       t_d.cnt = cnt_inc;
                    end
                end
            end
            default: t_d.state = ST_IDLE;
        endcase

        if (load) begin
            t_d.act_hi  = sh_hi_i;
            t_d.act_lo  = sh_lo_i;
            t_d.act_div = sh_div_i;
            t_d.ph      = 1'b1;
            t_d.cnt     = '0;
        end
        if (t_d.state != ST_RUN) begin
            t_d.cnt = '0;
            t_d.ph  = 1'b1;
        end
        t_d.lat = (t_d.state == ST_RUN) && (t_d.act_hi != '0)
                  && (t_d.ph || t_d.act_lo == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{state: ST_IDLE, ph: 1'b1, cnt: '0, act_hi: '0,
                     act_lo: '0, act_div: '0, lat: 1'b0};
        end else begin
            t_q <= t_d;
        end
    end

    assign running_o = (t_q.state == ST_RUN);
    assign div_o     = t_q.act_div;
    assign pwm_o     = t_q.lat;

    // a cleared enable forces the output low on the next edge
    assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pwm_o)
        else $error("output high after enable cleared");

    // the phase counter stays below the register of the active phase
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && t_q.act_hi != '0 && t_q.act_lo != '0)
        |-> (t_q.ph ? (t_q.cnt < t_q.act_hi) : (t_q.cnt < t_q.act_lo)))
        else $error("phase counter reached its limit");

    // during a high phase the working settings do not move
    assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && t_q.ph && t_q.act_hi != '0 && t_q.act_lo != '0)
        |=> (!running_o || ($stable(t_q.act_hi) && $stable(t_q.act_lo)
                            && $stable(t_q.act_div))))
        else $error("working settings changed mid-period");

    assert_zero_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && t_q.act_hi == '0) |-> !pwm_o)
        else $error("output high with zero high time");

    assert_zero_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && t_q.act_hi != '0 && t_q.act_lo == '0) |-> pwm_o)
        else $error("output low with zero low time");

endmodule

// File: rtl/pwm_hilo_channel.sv
module pwm_hilo_channel
    import pwm_hilo_pkg::*;
#(
    parameter int TIME_W      = 16,
    parameter int DIV_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [TIME_W-1:0] cfg_wdata,
    input  logic              evt_in,
    output logic              pwm_out
);
    localparam int EN_BIT  = DIV_W;
    localparam int EVM_BIT = DIV_W + 1;

    typedef struct packed {
        logic [TIME_W-1:0] hi;
        logic [TIME_W-1:0] lo;
        logic [DIV_W-1:0]  div;
        logic              en;
        logic              evm;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_addr)
                ADR_HIGH: cfg_d.hi = cfg_wdata;
                ADR_LOW:  cfg_d.lo = cfg_wdata;
                ADR_CTRL: begin
                    cfg_d.div = cfg_wdata[DIV_W-1:0];
                    cfg_d.en  = cfg_wdata[EN_BIT];
                    cfg_d.evm = cfg_wdata[EVM_BIT];
                end
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    logic             evt_rise;
    logic             step;
    logic             running;
    logic [DIV_W-1:0] act_div;

    pwm_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_in),
        .rise_o (evt_rise)
    );

    pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .tick_i (base_tick),
        .div_i  (act_div),
        .step_o (step)
    );

    pwm_phase_timer #(.TIME_W(TIME_W), .DIV_W(DIV_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (cfg_q.en),
        .evm_i      (cfg_q.evm),
        .evt_rise_i (evt_rise),
        .step_i     (step),
        .sh_hi_i    (cfg_q.hi),
        .sh_lo_i    (cfg_q.lo),
        .sh_div_i   (cfg_q.div),
        .running_o  (running),
        .div_o      (act_div),
        .pwm_o      (pwm_out)
    );

    // the output stays low while no enable is held
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.en && !$past(cfg_q.en)) |-> !pwm_out)
        else $error("output high while disabled");

endmodule

// File: tb/tb_pwm_hilo_channel.sv
module tb_pwm_hilo_channel;

    localparam int TICK_P = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        evt_in = 1'b0;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic  lvl;
        int    len;
        string req;
    } exp_t;

    exp_t exp_q[$];
    bit   armed = 1'b0;
    int   skip_n = 0;
    logic prev_lvl = 1'b0;
    int   run_len = 0;

    pwm_hilo_channel dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .evt_in    (evt_in),
        .pwm_out   (pwm_out)
    );

    always #5 clk = ~clk;

    always @(negedge clk) base_tick <= ~base_tick;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: measure each completed output run and compare with the queue
    always @(negedge clk) begin
        if (pwm_out !== prev_lvl) begin
            if (armed) begin
                if (skip_n > 0) skip_n--;
                else if (exp_q.size() > 0) begin
                    exp_t it;
                    it = exp_q.pop_front();
                    check({it.req, " level"}, int'(prev_lvl), int'(it.lvl));
                    check({it.req, " length"}, run_len, it.len);
                end
            end
            prev_lvl = pwm_out;
            run_len  = 1;
        end else begin
            run_len++;
        end
    end

    task automatic cfg_write(input logic [1:0] a, input int v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = 16'(v);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic push(input logic lvl, input int v, input int n, input string req);
        exp_t it;
        it.lvl = lvl;
        it.len = v * (1 << n) * TICK_P;
        it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic drain(input string req);
        int g = 0;
        while (exp_q.size() != 0 && g < 40000) begin
            @(negedge clk);
            g++;
        end
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL %s: actual %0d runs missing expected 0", req, exp_q.size());
            exp_q.delete();
        end
        @(negedge clk);
        #1 armed = 1'b0;
    endtask

    // driver: configure a channel and queue the phase lengths it must produce
    task automatic run_case(input int hi, input int lo, input int n);
        cfg_write(2'd2, 0);
        repeat (4) @(negedge clk);
        cfg_write(2'd0, hi);
        cfg_write(2'd1, lo);
        #1;
        skip_n = 2;
        armed  = 1'b1;
        push(1'b0, lo, n, "R3");
        push(1'b1, hi, n, "R2");
        push(1'b0, lo, n, "R3");
        push(1'b1, hi, n, "R4");
        cfg_write(2'd2, 8 | n);
        drain("R2");
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int cnt;
        repeat (5) @(negedge clk);
        check("R1 output during reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 output after reset", int'(pwm_out), 0);

        run_case(3, 5, 0);
        run_case(2, 1, 2);
        run_case(1, 1, 0);
        run_case(4, 2, 7);

        // R5: rewrite settings during a high phase
        cfg_write(2'd2, 0);
        repeat (4) @(negedge clk);
        cfg_write(2'd0, 3);
        cfg_write(2'd1, 5);
        cfg_write(2'd2, 8);
        @(posedge pwm_out);
        @(posedge pwm_out);
        @(negedge clk);
        #1;
        skip_n = 0;
        armed  = 1'b1;
        push(1'b1, 3, 0, "R5 old high");
        push(1'b0, 5, 0, "R5 old low");
        push(1'b1, 6, 0, "R5 new high");
        push(1'b0, 2, 0, "R5 new low");
        cfg_write(2'd0, 6);
        cfg_write(2'd1, 2);
        drain("R5");

        // R6: zero high time
        cfg_write(2'd2, 0);
        repeat (4) @(negedge clk);
        cfg_write(2'd0, 0);
        cfg_write(2'd1, 5);
        cfg_write(2'd2, 8);
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pwm_out) cnt++;
        end
        check("R6 high cycles", cnt, 0);

        // R7: zero low time
        cfg_write(2'd2, 0);
        repeat (4) @(negedge clk);
        cfg_write(2'd0, 4);
        cfg_write(2'd1, 0);
        cfg_write(2'd2, 8);
        repeat (3) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!pwm_out) cnt++;
        end
        check("R7 low cycles", cnt, 0);

        // R8 / R9: enable and disable latency
        cfg_write(2'd2, 0);
        repeat (4) @(negedge clk);
        cfg_write(2'd0, 50);
        cfg_write(2'd1, 50);
        cfg_write(2'd2, 8);
        check("R8 one edge after write", int'(pwm_out), 0);
        @(negedge clk);
        check("R8 two edges after write", int'(pwm_out), 1);
        repeat (5) @(negedge clk);
        cfg_write(2'd2, 0);
        check("R9 one edge after write", int'(pwm_out), 1);
        @(negedge clk);
        check("R9 two edges after write", int'(pwm_out), 0);
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (pwm_out) cnt++;
        end
        check("R9 stays low", cnt, 0);

        // R10: event-triggered start
        cfg_write(2'd2, 8 | 16);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_out) cnt++;
        end
        check("R10 waiting output", cnt, 0);
        evt_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 two edges after event", int'(pwm_out), 0);
        @(negedge clk);
        check("R10 three edges after event", int'(pwm_out), 1);
        evt_in = 1'b0;
        cfg_write(2'd2, 0);
        repeat (4) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule